// File: doc/BRIEF.md
# Paired-Bank Video Memory with Shared-Port Arbitration

This block holds the display memory of a character-cell video system. To the processor it looks like one flat, byte-addressed region. Inside, the bytes are kept in two banks of equal size. Bytes at even addresses go in one bank and bytes at odd addresses go in the other. Because of this split, the display fetch reads a character code and its attribute byte together, from the same index of both banks, in a single cycle.

Each bank is a synchronous RAM with one port. Every cycle, one port per bank is shared between the display fetch and the processor. A mode input selects how a collision between the two is resolved:

- **Slow policy:** the display always wins. The processor is told to wait and must hold its request.
- **Fast policy:** the processor always wins. The display fetch is redirected to the processor's location, and a glitch flag marks the resulting data as corrupt.

Top module: `paired_bank_vram`

## Requirements
- R1: A processor write to byte address A changes only one byte. Address bit 0 picks the bank: 0 selects the even bank, 1 selects the odd bank. Bits [11:1] give the index inside that bank. The byte at the same index in the other bank is unchanged.
- R2: When `vid_req` is high and the display owns the port, index `vid_idx` is read from both banks. One cycle later, `vid_char` carries the even-bank byte and `vid_attr` carries the odd-bank byte.
- R3: A granted read has `cpu_rd` high, `cpu_we` low and `cpu_wait` low. On the cycle after the grant, `cpu_rdata` carries the byte at the requested address. The bank is chosen by the registered address bit 0.
- R4: In the slow policy (`fast_mode` = 0), a processor request that meets `vid_req` in the same cycle raises `cpu_wait` in that cycle. That request writes nothing. The display is served as usual.
- R5: A stalled request that is held is performed in the first cycle in which `vid_req` is low, and `cpu_wait` falls combinationally in that same cycle.
- R6: In the fast policy (`fast_mode` = 1), `cpu_wait` stays low once reset has been released, and the processor access is performed even when `vid_req` is high.
- R7: If, in the fast policy, a processor request meets `vid_req`:
  - `vid_glitch` is 1 in the following cycle.
  - `vid_char` and `vid_attr` then show the bytes at the processor's index, not at `vid_idx`.
  - In every other case `vid_glitch` is 0 in the following cycle.
- R8: Reset (`rst_n` low) is asynchronous and is released synchronously.
  - While reset is held, `vid_glitch` is 0.
  - While reset is held, any processor request sees `cpu_wait` = 1 and writes nothing.
  - Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 = processor has priority, 0 = display has priority |
| cpu_addr | input | 12 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write request (a write takes precedence over `cpu_rd`) |
| cpu_rd | input | 1 | Processor read request |
| cpu_wait | output | 1 | Request not taken this cycle; hold it |
| cpu_rdata | output | 8 | Read data, valid the cycle after a granted read |
| vid_req | input | 1 | Display fetch request |
| vid_idx | input | 11 | Display fetch index (pair index) |
| vid_char | output | 8 | Even-bank byte of the fetched pair |
| vid_attr | output | 8 | Odd-bank byte of the fetched pair |
| vid_glitch | output | 1 | Fetched pair was displaced by a processor access |

## Verification
The block produces results on two timings:

- **Same cycle:** `cpu_wait` is combinational, so it is due in the very cycle its inputs are applied. The bench samples it one time unit after driving each vector, before the next rising edge.
- **One cycle later:** read data, display bytes and the glitch flag each pass through exactly one register. They are due in the cycle after the request, and the bench samples them one time unit after the following rising edge, while that vector's inputs are still held.

The bench confirms that a stalled write did not land by reading the affected pair back through the display port on the next vector.

// File: rtl/pbv_pkg.sv
package pbv_pkg;

  // Owner of the shared bank port in the current cycle
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_VID  = 2'd1,
    OWN_CPU  = 2'd2,
    OWN_OVR  = 2'd3   // processor displacing a display fetch
  } port_owner_e;

endpackage

// File: rtl/pbv_rst_sync.sv
module pbv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/pbv_bank.sv
module pbv_bank #(
  parameter int IDX_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // Read-first single port with clock enable
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      rdata_q <= mem[idx];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/pbv_arbiter.sv
module pbv_arbiter
  import pbv_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic              rst_ok,
  input  logic              fast_mode,
  input  logic              vid_req,
  input  logic [IDX_W-1:0]  vid_idx,
  input  logic              cpu_we,
  input  logic              cpu_rd,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic              cpu_odd,
  output port_owner_e       owner,
  output logic              port_en,
  output logic [IDX_W-1:0]  port_idx,
  output logic              we_even,
  output logic              we_odd,
  output logic              cpu_grant,
  output logic              cpu_wait
);

  logic cpu_req;

  always_comb begin
    cpu_req = cpu_we | cpu_rd;
    if (!rst_ok)                 owner = OWN_IDLE;
    else if (vid_req && cpu_req) owner = fast_mode ? OWN_OVR : OWN_VID;
    else if (vid_req)            owner = OWN_VID;
    else if (cpu_req)            owner = OWN_CPU;
    else                         owner = OWN_IDLE;

    cpu_grant = (owner == OWN_CPU) || (owner == OWN_OVR);
    port_en   = (owner != OWN_IDLE);
    port_idx  = cpu_grant ? cpu_idx : vid_idx;
    we_even   = cpu_grant & cpu_we & ~cpu_odd;
    we_odd    = cpu_grant & cpu_we &  cpu_odd;
    cpu_wait  = cpu_req & ~cpu_grant;
  end

endmodule

// File: rtl/paired_bank_vram.sv
module paired_bank_vram
  import pbv_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fast_mode,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                cpu_we,
  input  logic                cpu_rd,
  output logic                cpu_wait,
  output logic [DATA_W-1:0]   cpu_rdata,
  input  logic                vid_req,
  input  logic [ADDR_W-2:0]   vid_idx,
  output logic [DATA_W-1:0]   vid_char,
  output logic [DATA_W-1:0]   vid_attr,
  output logic                vid_glitch
);

  localparam int IDX_W  = ADDR_W - 1;
  localparam int NBANKS = 2;

  logic              rst_sync_n;
  port_owner_e       owner;
  logic              port_en;
  logic [IDX_W-1:0]  port_idx;
  logic              we_even, we_odd, cpu_grant;
  logic              bank_we [NBANKS];
  logic [DATA_W-1:0] bank_q  [NBANKS];

  logic rd_sel_d, rd_sel_q;
  logic glitch_d, glitch_q;

  pbv_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  pbv_arbiter #(.IDX_W(IDX_W)) arb_i (
    .rst_ok(rst_sync_n), .fast_mode(fast_mode),
    .vid_req(vid_req), .vid_idx(vid_idx),
    .cpu_we(cpu_we), .cpu_rd(cpu_rd),
    .cpu_idx(cpu_addr[ADDR_W-1:1]), .cpu_odd(cpu_addr[0]),
    .owner(owner), .port_en(port_en), .port_idx(port_idx),
    .we_even(we_even), .we_odd(we_odd),
    .cpu_grant(cpu_grant), .cpu_wait(cpu_wait)
  );

  assign bank_we[0] = we_even;
  assign bank_we[1] = we_odd;

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    pbv_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) bank_i (
      .clk(clk), .en(port_en), .we(bank_we[g]),
      .idx(port_idx), .wdata(cpu_wdata), .rdata(bank_q[g])
    );
  end

  // Next state
  always_comb begin
    rd_sel_d = rd_sel_q;
    if (cpu_grant && cpu_rd && !cpu_we) rd_sel_d = cpu_addr[0];
    glitch_d = (owner == OWN_OVR);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_sel_q <= 1'b0;
      glitch_q <= 1'b0;
    end else begin
      rd_sel_q <= rd_sel_d;
      glitch_q <= glitch_d;
    end
  end

  assign vid_char   = bank_q[0];
  assign vid_attr   = bank_q[1];
  assign cpu_rdata  = rd_sel_q ? bank_q[1] : bank_q[0];
  assign vid_glitch = glitch_q;

  // R1
  one_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({we_even, we_odd}));

  // R3
  rd_sel_track_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd && !cpu_we && !cpu_wait) |=> (rd_sel_q == $past(cpu_addr[0])));

  // R4
  stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_wait |-> !(we_even || we_odd));

  // R5
  free_port_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cpu_we || cpu_rd) && !vid_req) |-> !cpu_wait);

  // R6
  fast_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fast_mode |-> !cpu_wait);

  // R7
  glitch_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vid_glitch |-> $past(fast_mode && vid_req && (cpu_we || cpu_rd)));

endmodule

// File: tb/paired_bank_vram_tb.sv
module paired_bank_vram_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fast_mode;
  logic [11:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we, cpu_rd;
  logic        cpu_wait;
  logic [7:0]  cpu_rdata;
  logic        vid_req;
  logic [10:0] vid_idx;
  logic [7:0]  vid_char, vid_attr;
  logic        vid_glitch;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  paired_bank_vram dut_i (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rd(cpu_rd),
    .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata),
    .vid_req(vid_req), .vid_idx(vid_idx),
    .vid_char(vid_char), .vid_attr(vid_attr), .vid_glitch(vid_glitch)
  );

  typedef struct packed {
    logic        fast;
    logic        vreq;
    logic [10:0] vidx;
    logic        we;
    logic        rd;
    logic [11:0] addr;
    logic [7:0]  wd;
    logic        ewait;
    logic        chkv;
    logic [7:0]  echar;
    logic [7:0]  eattr;
    logic        chkr;
    logic [7:0]  erd;
    logic        eglt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R1 writes steered by bit 0
    '{1'b0,1'b0,11'h000,1'b1,1'b0,12'h010,8'h41,1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,4'd1},
    '{1'b0,1'b0,11'h000,1'b1,1'b0,12'h011,8'h1E,1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,4'd1},
    // R2 pair fetch
    '{1'b0,1'b1,11'h008,1'b0,1'b0,12'h000,8'h00,1'b0,1'b1,8'h41,8'h1E,1'b0,8'h00,1'b0,4'd2},
    // R3 reads
    '{1'b0,1'b0,11'h000,1'b0,1'b1,12'h010,8'h00,1'b0,1'b0,8'h00,8'h00,1'b1,8'h41,1'b0,4'd3},
    '{1'b0,1'b0,11'h000,1'b0,1'b1,12'h011,8'h00,1'b0,1'b0,8'h00,8'h00,1'b1,8'h1E,1'b0,4'd3},
    // R4 slow collision: stalled write, display served
    '{1'b0,1'b1,11'h008,1'b1,1'b0,12'h010,8'h99,1'b1,1'b1,8'h41,8'h1E,1'b0,8'h00,1'b0,4'd4},
    '{1'b0,1'b1,11'h008,1'b0,1'b0,12'h000,8'h00,1'b0,1'b1,8'h41,8'h1E,1'b0,8'h00,1'b0,4'd4},
    // R1 write even byte, odd neighbour unchanged
    '{1'b0,1'b0,11'h000,1'b1,1'b0,12'h010,8'h99,1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,4'd1},
    '{1'b0,1'b1,11'h008,1'b0,1'b0,12'h000,8'h00,1'b0,1'b1,8'h99,8'h1E,1'b0,8'h00,1'b0,4'd1},
    '{1'b0,1'b0,11'h000,1'b1,1'b0,12'hFFE,8'hC3,1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,4'd1},
    // R7 fast collision read: display redirected, glitch raised
    '{1'b1,1'b1,11'h000,1'b0,1'b1,12'h011,8'h00,1'b0,1'b1,8'h99,8'h1E,1'b1,8'h1E,1'b1,4'd7},
    // R6 fast collision write proceeds without wait
    '{1'b1,1'b1,11'h008,1'b1,1'b0,12'hFFF,8'h5A,1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b1,4'd6},
    '{1'b0,1'b1,11'h7FF,1'b0,1'b0,12'h000,8'h00,1'b0,1'b1,8'hC3,8'h5A,1'b0,8'h00,1'b0,4'd6},
    // R7 fast, no collision: no glitch
    '{1'b1,1'b1,11'h008,1'b0,1'b0,12'h000,8'h00,1'b0,1'b1,8'h99,8'h1E,1'b0,8'h00,1'b0,4'd7},
    '{1'b1,1'b0,11'h000,1'b0,1'b1,12'hFFE,8'h00,1'b0,1'b0,8'h00,8'h00,1'b1,8'hC3,1'b0,4'd3},
    '{1'b0,1'b1,11'h7FF,1'b0,1'b0,12'h000,8'h00,1'b0,1'b1,8'hC3,8'h5A,1'b0,8'h00,1'b0,4'd2}
  };

  task automatic chk(input string what, input int req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    fast_mode = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    cpu_we = 1'b0; cpu_rd = 1'b0; vid_req = 1'b0; vid_idx = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    #1;
    chk("glitch in reset", 8, {7'd0, vid_glitch}, 8'h00);   // R8
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("glitch after reset", 8, {7'd0, vid_glitch}, 8'h00); // R8
    chk("wait when idle", 5, {7'd0, cpu_wait}, 8'h00);      // R5

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fast_mode = VEC[i].fast; vid_req = VEC[i].vreq; vid_idx = VEC[i].vidx;
      cpu_we = VEC[i].we; cpu_rd = VEC[i].rd;
      cpu_addr = VEC[i].addr; cpu_wdata = VEC[i].wd;
      #1;
      chk($sformatf("vec %0d wait", i), VEC[i].req, {7'd0, cpu_wait}, {7'd0, VEC[i].ewait});
      @(posedge clk); #1;
      if (VEC[i].chkv) begin
        chk($sformatf("vec %0d char", i), VEC[i].req, vid_char, VEC[i].echar);
        chk($sformatf("vec %0d attr", i), VEC[i].req, vid_attr, VEC[i].eattr);
      end
      if (VEC[i].chkr)
        chk($sformatf("vec %0d rdata", i), VEC[i].req, cpu_rdata, VEC[i].erd);
      chk($sformatf("vec %0d glitch", i), VEC[i].req, {7'd0, vid_glitch}, {7'd0, VEC[i].eglt});
    end

    // R5: held read waits out three display cycles, then completes
    @(negedge clk);
    idle_inputs();
    vid_req = 1'b1; vid_idx = 11'h100; cpu_rd = 1'b1; cpu_addr = 12'h011;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("held read waits", 5, {7'd0, cpu_wait}, 8'h01);
      @(negedge clk);
    end
    vid_req = 1'b0;
    #1;
    chk("wait drops with video", 5, {7'd0, cpu_wait}, 8'h00);
    @(posedge clk); #1;
    chk("held read data", 5, cpu_rdata, 8'h1E);

    // R8: glitch cleared by reset, write blocked during reset
    @(negedge clk);
    fast_mode = 1'b1; vid_req = 1'b1; cpu_rd = 1'b1; cpu_addr = 12'h010;
    @(posedge clk); #1;
    chk("glitch before reset", 7, {7'd0, vid_glitch}, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    cpu_we = 1'b1; cpu_addr = 12'h010; cpu_wdata = 8'h77;
    #1;
    chk("glitch cleared by reset", 8, {7'd0, vid_glitch}, 8'h00);
    chk("wait during reset", 8, {7'd0, cpu_wait}, 8'h01);
    repeat (2) @(negedge clk);
    idle_inputs();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 12'h010;
    @(posedge clk); #1;
    chk("no write in reset, contents kept", 8, cpu_rdata, 8'h99);
    @(negedge clk);
    idle_inputs();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule